// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a software-serviced watchdog. The CPU clock passes through a prescaler whose ratio depends on a clock-source strap and a divide-select bit. Each prescaler tick decrements a down-counter. If software does not reload the counter before it runs out, the block raises an interrupt request or a reset request, depending on a static response-select input.

Software reaches the block through a byte-wide write port with a small address field. A reload is accepted only after an unlock key followed by the reload key, and it restores the counter without touching the prescaler phase. A strap decides whether counting begins on its own after reset or waits for a write to the start register. Low-power and flash-programming inputs freeze both the counter and the prescaler, and counting resumes from the held value. The counter value is visible on a status output.

Top module: `wdog_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `count_val` equals all ones (2^CNT_W-1), `irq` is 0 and `rst_req` is 0. The prescaler is cleared and the divide-select bit is 0.
- R2: The counter decrements by one on each prescaler tick. With `sub_clk_sel` low, a tick occurs every DIV_LO enabled cycles when divide-select is 0 and every DIV_HI enabled cycles when it is 1. Divide-select is bit 0 of a write to address 2.
- R3: With `sub_clk_sel` high, a tick occurs every DIV_SUB enabled cycles, whatever the divide-select bit holds.
- R4: A tick that arrives while the counter is zero is an underflow, and the counter reloads to all ones on that edge. From reset, underflow occurs on enabled cycle ratio*(2^CNT_W).
- R5: Writing 00h to address 0 and then, as the next write to address 0, writing FFh reloads the counter to all ones on the edge of the FFh write.
- R6: A reload leaves the prescaler phase unchanged, so the next tick arrives when it would have arrived without the reload.
- R7: A write of FFh to address 0 that does not directly follow a 00h write to address 0 has no effect. Any other value written between the 00h and the FFh cancels the unlock. Writes to other addresses leave the unlock state alone.
- R8: With `start_hold` low, counting begins right after reset. With it high, the counter and prescaler stay still until any write to address 1, and counting begins on the cycle after that write.
- R9: While `wait_mode`, `stop_mode` or `flash_busy` is high, the counter and prescaler hold their values. When all three are low again, counting resumes from the held state.
- R10: With `resp_reset` low, an underflow sets `irq` on the same edge as the reload, for exactly one cycle. `rst_req` stays 0.
- R11: With `resp_reset` high, an underflow sets `rst_req` on the same edge as the reload. It stays high until `rst` is asserted, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 start, 2 control |
| wr_data | input | 8 | Write data |
| sub_clk_sel | input | 1 | Static: low-speed clock source selected, ratio fixed to DIV_SUB |
| start_hold | input | 1 | Static strap: 1 keeps the timer stopped after reset |
| resp_reset | input | 1 | Static: 1 selects reset request on underflow, 0 selects interrupt |
| wait_mode | input | 1 | Wait mode active, freezes counting |
| stop_mode | input | 1 | Stop mode active, freezes counting |
| flash_busy | input | 1 | Flash programming active, freezes counting |
| irq | output | 1 | One-cycle interrupt request on underflow |
| rst_req | output | 1 | Held reset request on underflow |
| count_val | output | CNT_W | Current counter value |

## Verification
The bench builds the block with a 4-bit counter and prescaler ratios of 4, 8 and 2, in place of 15 bits and 16/128/2. A full period then fits in a few dozen cycles, so the bench can observe underflow, interrupt versus reset response, and reload timing relative to the prescaler phase. The shorter ratios also make it practical to compare each ratio cycle by cycle. This includes ignoring the divide-select bit on the low-speed source, and a freeze that lands in the middle of a prescaler period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
    localparam logic [ADDR_W-1:0] A_START  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    localparam logic [7:0] KEY_UNLOCK = 8'h00;
    localparam logic [7:0] KEY_RELOAD = 8'hFF;

    typedef enum logic {
        UL_IDLE  = 1'b0,
        UL_ARMED = 1'b1
    } unlock_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } bus_wr_t;

    typedef struct packed {
        logic run;
        logic div_hi;
        logic reload;
    } wdt_ctl_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_hold,
    input  bus_wr_t  bus,
    output wdt_ctl_t ctl
);

    unlock_e ul_q;
    logic    run_q;
    logic    div_q;
    logic    hit_reload;
    logic    hit_start;
    logic    hit_ctrl;

    always_comb begin
        hit_reload = bus.wr && (bus.addr == A_RELOAD);
        hit_start  = bus.wr && (bus.addr == A_START);
        hit_ctrl   = bus.wr && (bus.addr == A_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ul_q  <= UL_IDLE;
            run_q <= ~start_hold;
            div_q <= 1'b0;
        end else begin
            if (hit_reload)
                ul_q <= (bus.data == KEY_UNLOCK) ? UL_ARMED : UL_IDLE;
            if (hit_start)
                run_q <= 1'b1;
            if (hit_ctrl)
                div_q <= bus.data[0];
        end
    end

    always_comb begin
        ctl.run    = run_q;
        ctl.div_hi = div_q;
        ctl.reload = hit_reload && (ul_q == UL_ARMED) && (bus.data == KEY_RELOAD);
    end

    // R8
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |=> run_q);

    // R7
    unlock_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.reload |=> (ul_q == UL_IDLE));

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int DIV_LO  = 16,
    parameter int DIV_HI  = 128,
    parameter int DIV_SUB = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sub_sel,
    input  logic div_hi,
    output logic tick
);

    localparam int PMAX = max3(DIV_LO, DIV_HI, DIV_SUB);
    localparam int PW   = (PMAX > 2) ? $clog2(PMAX) : 1;
    localparam logic [PW-1:0] LIM_LO  = PW'(DIV_LO - 1);
    localparam logic [PW-1:0] LIM_HI  = PW'(DIV_HI - 1);
    localparam logic [PW-1:0] LIM_SUB = PW'(DIV_SUB - 1);

    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        if (sub_sel)
            lim = LIM_SUB;
        else if (div_hi)
            lim = LIM_HI;
        else
            lim = LIM_LO;
    end

    // ">=" keeps a ratio change from skipping past the terminal value
    assign tick = en && (pcnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt_q <= '0;
        else if (en)
            pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
    end

    // R9
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pcnt_q));

    // R2
    pre_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt_q == '0));

endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             uf
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    assign uf  = tick && !reload && (cnt_q == '0);
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || reload)
            cnt_q <= TOP;
        else if (tick)
            cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
    end

    // R4
    uf_reload_chk: assert property (@(posedge clk) disable iff (rst)
        uf |=> (cnt_q == TOP));

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !reload && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp (
    input  logic clk,
    input  logic rst,
    input  logic uf,
    input  logic resp_reset,
    output logic irq,
    output logic rst_req
);

    logic irq_q;
    logic rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            rr_q  <= 1'b0;
        end else begin
            irq_q <= uf && !resp_reset;
            rr_q  <= rr_q || (uf && resp_reset);
        end
    end

    assign irq     = irq_q;
    assign rst_req = rr_q;

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R11
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rr_q |=> rr_q);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int DIV_LO  = 16,
    parameter int DIV_HI  = 128,
    parameter int DIV_SUB = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             sub_clk_sel,
    input  logic             start_hold,
    input  logic             resp_reset,
    input  logic             wait_mode,
    input  logic             stop_mode,
    input  logic             flash_busy,
    output logic             irq,
    output logic             rst_req,
    output logic [CNT_W-1:0] count_val
);

    bus_wr_t  bus;
    wdt_ctl_t ctl;
    logic     frozen;
    logic     pre_en;
    logic     tick;
    logic     uf;

    always_comb begin
        bus.wr   = wr_en;
        bus.addr = wr_addr;
        bus.data = wr_data;
        frozen   = wait_mode || stop_mode || flash_busy;
        pre_en   = ctl.run && !frozen;
    end

    wdt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .start_hold (start_hold),
        .bus        (bus),
        .ctl        (ctl)
    );

    wdt_prescale #(
        .DIV_LO  (DIV_LO),
        .DIV_HI  (DIV_HI),
        .DIV_SUB (DIV_SUB)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (pre_en),
        .sub_sel (sub_clk_sel),
        .div_hi  (ctl.div_hi),
        .tick    (tick)
    );

    wdt_downcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .reload (ctl.reload),
        .cnt    (count_val),
        .uf     (uf)
    );

    wdt_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .uf         (uf),
        .resp_reset (resp_reset),
        .irq        (irq),
        .rst_req    (rst_req)
    );

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !ctl.reload) |=> $stable(count_val));

    // R5
    reload_top_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.reload |=> (count_val == {CNT_W{1'b1}}));

    // R10
    uf_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (uf && !resp_reset) |=> irq);

    // R11
    uf_rr_chk: assert property (@(posedge clk) disable iff (rst)
        (uf && resp_reset) |=> (rst_req && !irq));

endmodule

// File: tb/wdog_core_test.sv
`timescale 1ns/1ps
module wdog_core_test;
    import wdt_pkg::*;

    localparam int CW   = 4;
    localparam int DL   = 4;
    localparam int DH   = 8;
    localparam int DS   = 2;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              sub_sel = 1'b0;
    logic              hold = 1'b0;
    logic              resp = 1'b0;
    logic              wt = 1'b0;
    logic              sp = 1'b0;
    logic              fl = 1'b0;
    logic              irq;
    logic              rst_req;
    logic [CW-1:0]     count_val;

    wdog_core #(.CNT_W(CW), .DIV_LO(DL), .DIV_HI(DH), .DIV_SUB(DS)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sub_clk_sel(sub_sel), .start_hold(hold), .resp_reset(resp),
        .wait_mode(wt), .stop_mode(sp), .flash_busy(fl),
        .irq(irq), .rst_req(rst_req), .count_val(count_val)
    );

    typedef struct {
        string tag;
        int    cnt;
        int    irq;
        int    rr;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;

    task automatic expect_out(input string tag, input int c, input int i, input int r);
        exp_t e;
        e.tag = tag; e.cnt = c; e.irq = i; e.rr = r;
        sbq.push_back(e);
    endtask

    // monitor: pops expected items and compares after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                if (e.cnt >= 0) begin
                    n_chk++;
                    if (int'(count_val) != e.cnt) begin
                        n_fail++;
                        $display("FAIL %s count_val actual=%0d expected=%0d", e.tag, count_val, e.cnt);
                    end
                end
                if (e.irq >= 0) begin
                    n_chk++;
                    if (int'(irq) != e.irq) begin
                        n_fail++;
                        $display("FAIL %s irq actual=%0d expected=%0d", e.tag, irq, e.irq);
                    end
                end
                if (e.rr >= 0) begin
                    n_chk++;
                    if (int'(rst_req) != e.rr) begin
                        n_fail++;
                        $display("FAIL %s rst_req actual=%0d expected=%0d", e.tag, rst_req, e.rr);
                    end
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic h, input logic sb, input logic rs);
        @(negedge clk);
        rst = 1'b1; hold = h; sub_sel = sb; resp = rs;
        wr_en = 1'b0; wt = 1'b0; sp = 1'b0; fl = 1'b0;
        step(2);
        expect_out("R1 reset state", MAXV, 0, 0);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // auto start, divide by DL, interrupt response
        do_reset(1'b0, 1'b0, 1'b0);
        step(4);  expect_out("R2 first tick", 14, 0, 0);
        step(5);  expect_out("R2 second tick", 13, -1, -1);
        step(54); expect_out("R4 at zero", 0, 0, 0);
        step(1);  expect_out("R4 R10 underflow", MAXV, 1, 0);
        step(1);  expect_out("R10 pulse ends", MAXV, 0, 0);

        // reload sequence and prescaler phase kept
        do_reset(1'b0, 1'b0, 1'b0);
        step(9);  expect_out("R5 before reload", 13, -1, -1);
        wr(A_RELOAD, KEY_UNLOCK);
        wr(A_RELOAD, KEY_RELOAD);
        expect_out("R5 reload", MAXV, -1, -1);
        step(1);  expect_out("R6 phase kept", 14, -1, -1);

        // lone reload key
        do_reset(1'b0, 1'b0, 1'b0);
        step(9);
        wr(A_RELOAD, KEY_RELOAD);
        step(1);  expect_out("R7 lone key ignored", 13, -1, -1);

        // cancelled unlock
        do_reset(1'b0, 1'b0, 1'b0);
        step(9);
        wr(A_RELOAD, KEY_UNLOCK);
        wr(A_RELOAD, 8'h55);
        wr(A_RELOAD, KEY_RELOAD);
        expect_out("R7 cancelled unlock", 12, -1, -1);

        // divide select high
        do_reset(1'b0, 1'b0, 1'b0);
        wr(A_CTRL, 8'h01);
        step(6);  expect_out("R2 div high no tick yet", MAXV, -1, -1);
        step(1);  expect_out("R2 div high tick", 14, -1, -1);
        step(8);  expect_out("R2 div high second", 13, -1, -1);

        // low-speed source ignores divide select
        do_reset(1'b0, 1'b1, 1'b0);
        wr(A_CTRL, 8'h01);
        step(4);  expect_out("R3 sub ratio", 13, -1, -1);
        step(1);  expect_out("R3 sub ratio next", 12, -1, -1);

        // held after reset until start write
        do_reset(1'b1, 1'b0, 1'b0);
        step(20); expect_out("R8 held", MAXV, 0, 0);
        wr(A_START, 8'h00);
        step(3);  expect_out("R8 started no tick", MAXV, -1, -1);
        step(1);  expect_out("R8 started tick", 14, -1, -1);

        // freeze inputs
        do_reset(1'b0, 1'b0, 1'b0);
        step(9);
        wt = 1'b1; step(20); expect_out("R9 wait freeze", 13, -1, -1);
        wt = 1'b0; sp = 1'b1; step(5); expect_out("R9 stop freeze", 13, -1, -1);
        sp = 1'b0; fl = 1'b1; step(5); expect_out("R9 flash freeze", 13, -1, -1);
        fl = 1'b0;
        step(2);  expect_out("R9 resume phase", 13, -1, -1);
        step(1);  expect_out("R9 resume tick", 12, -1, -1);

        // reset response
        do_reset(1'b0, 1'b0, 1'b1);
        step(64); expect_out("R11 request set", MAXV, 0, 1);
        step(10); expect_out("R11 request held", -1, 0, 1);
        rst = 1'b1;
        step(1);  expect_out("R11 cleared by reset", MAXV, 0, 0);
        rst = 1'b0;

        step(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule